// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is an up-counter made of identical 4-bit stages. Each stage counts in modulo-16 binary on the rising clock edge. The stages are chained into one wider counter. All stages share the clock, a data input for presetting, an active-low load control, an active-low clear control and a "parallel" count enable. The "trickle" count enable enters the lowest stage. Each stage's terminal-count output drives the trickle enable of the stage above it. The whole chain therefore advances as a single binary number, and a carry crosses every nibble on the same edge.

The controls have a fixed order of precedence. Clear wins over load, load wins over count, and count wins over hold. The build-time parameter `ASYNC_CLR` selects how clear acts. When it is 1, a low on the clear input forces the count to zero at once, without waiting for a clock edge. When it is 0, the count goes to zero on the next rising edge.

The terminal-count output is combinational. A further chain of the same kind can use it as its trickle enable. Only the trickle enable gates it; the parallel enable has no effect on it.

Top module: `bincnt_chain`

## Requirements
- R1: When clear and load are both high and both count enables are high, `q` rises by one on each rising edge as a binary number of width STAGE_W*STAGES. It wraps from all ones to zero, and a carry out of any nibble reaches the next nibble on the same edge.
- R2: When clear and load are both high and `en_p` or `en_t` is low, `q` holds its value across the edge.
- R3: When clear is high and `load_n` is low, `q` takes `din` on the next rising edge, whatever the count enables are.
- R4: In the synchronous variant (ASYNC_CLR=0), a low `clr_n` makes `q` zero on the next rising edge. This overrides both load and count.
- R5: In the asynchronous variant (ASYNC_CLR=1), a low `clr_n` forces `q` to zero at once, between clock edges. `q` stays zero while `clr_n` is low.
- R6: `tc` is high exactly when `en_t` is high and `q` is all ones. `en_p` has no effect on `tc`.
- R7: Apart from the asynchronous clear, `q` changes only at a rising clock edge. In particular, the synchronous variant keeps its value when `clr_n` falls between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear (asynchronous or synchronous, as set by ASYNC_CLR) |
| load_n | input | 1 | Active-low preset enable |
| din | input | STAGE_W*STAGES | Preset value |
| en_p | input | 1 | Count enable shared by all stages |
| en_t | input | 1 | Count enable into the lowest stage; also gates `tc` |
| q | output | STAGE_W*STAGES | Current count |
| tc | output | 1 | Terminal count of the whole chain |

## Verification
The assertions check on every clock edge:
- the increment with wrap when both enables are high;
- holding when either enable is low;
- loading from `din`;
- clear to zero;
- the combinational terminal-count relation.

Only the bench scenarios can show that an asynchronous clear acts in the middle of a cycle, and that the synchronous variant ignores that same pulse until the edge. The bench also sweeps every control combination from a known preset state, and it checks carries across the nibble boundary and the full wrap against a behavioural model.

// File: rtl/bincnt_pkg.sv
// Package bincnt_pkg
// Shared types for the chained binary counter.
package bincnt_pkg;
    // Action a stage takes at the next rising edge, resolved by precedence.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/bincnt_mode_dec.sv
// Module bincnt_mode_dec
// Resolves the control inputs into a single action: clear, then load,
// then count, then hold.
// Assumes the controls are synchronous to the stage clock. The asynchronous
// clear path is handled in the stage register, not here.
module bincnt_mode_dec
    import bincnt_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      en_p,
    input  logic      en_t,
    output cnt_mode_e mode
);
    // Precedence decode of the four actions.
    always_comb begin
        if (!clr_n)
            mode = MODE_CLEAR;
        else if (!load_n)
            mode = MODE_LOAD;
        else if (en_p && en_t)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/bincnt_stage.sv
// Module bincnt_stage
// One presettable up-counter slice of width W, counting modulo 2**W.
// tc is combinational: en_t AND all bits of q high.
// Assumes ASYNC_CLR picks the clear style: 1 is an asynchronous clear,
// 0 is a synchronous clear at the next rising edge.
module bincnt_stage
    import bincnt_pkg::*;
#(
    parameter int W         = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_p,
    input  logic         en_t,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    cnt_mode_e    mode;
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;

    bincnt_mode_dec u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .mode   (mode)
    );

    // Next-state selection from the resolved action.
    always_comb begin
        unique case (mode)
            MODE_CLEAR: q_nxt = '0;
            MODE_LOAD:  q_nxt = din;
            MODE_COUNT: q_nxt = q_r + 1'b1;
            default:    q_nxt = q_r;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async
            // State register with immediate clear.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    q_r <= '0;
                else
                    q_r <= q_nxt;
            end
        end else begin : g_sync
            // State register; clear arrives through q_nxt at the edge.
            always_ff @(posedge clk) begin
                q_r <= q_nxt;
            end
        end
    endgenerate

    assign q  = q_r;
    assign tc = en_t && (q_r == ALL_ONES);
endmodule

// File: rtl/bincnt_chain.sv
// Module bincnt_chain
// Chains STAGES counter slices of STAGE_W bits into one synchronous counter.
// Each slice's tc feeds the next slice's en_t. Clock, clear, load and en_p
// are common to all slices.
// Assumes all control inputs are synchronous to clk, except clr_n when
// ASYNC_CLR=1.
module bincnt_chain #(
    parameter int STAGE_W   = 4,
    parameter int STAGES    = 2,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic [STAGE_W*STAGES-1:0]   din,
    input  logic                        en_p,
    input  logic                        en_t,
    output logic [STAGE_W*STAGES-1:0]   q,
    output logic                        tc
);
    localparam int W = STAGE_W * STAGES;

    logic [STAGES:0] carry;

    assign carry[0] = en_t;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            bincnt_stage #(
                .W         (STAGE_W),
                .ASYNC_CLR (ASYNC_CLR)
            ) u_stage (
                .clk    (clk),
                .clr_n  (clr_n),
                .load_n (load_n),
                .din    (din[i*STAGE_W +: STAGE_W]),
                .en_p   (en_p),
                .en_t   (carry[i]),
                .q      (q[i*STAGE_W +: STAGE_W]),
                .tc     (carry[i+1])
            );
        end
    endgenerate

    assign tc = carry[STAGES];
endmodule

// File: rtl/bincnt_chain_chk.sv
// Module bincnt_chain_chk
// Port-level checker for bincnt_chain, attached through bind.
// Assumes clr_n is released only away from the rising edge.
module bincnt_chain_chk #(
    parameter int W         = 8,
    parameter bit ASYNC_CLR = 1'b0
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         en_p,
    input logic         en_t,
    input logic [W-1:0] q,
    input logic         tc
);
    logic armed = 1'b0;

    // Enables properties once the first edge has passed.
    always_ff @(posedge clk) armed <= 1'b1;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n || !armed)
        (load_n && en_p && en_t) |=> (q == W'($past(q) + 1'b1))); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n || !armed)
        (load_n && !(en_p && en_t)) |=> $stable(q)); // R2

    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!clr_n || !armed)
        !load_n |=> (q == $past(din))); // R3

    AST_CLEAR_AT_EDGE: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q == '0)); // R4

    AST_ASYNC_CLEAR_LOW: assert property (@(posedge clk) disable iff (!armed)
        (ASYNC_CLR && !clr_n) |-> (q == '0)); // R5

    AST_TERM_COUNT: assert property (@(posedge clk) disable iff (!armed)
        tc == (en_t && (q == {W{1'b1}}))); // R6
endmodule

bind bincnt_chain bincnt_chain_chk #(
    .W         (W),
    .ASYNC_CLR (ASYNC_CLR)
) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .din    (din),
    .en_p   (en_p),
    .en_t   (en_t),
    .q      (q),
    .tc     (tc)
);

// File: tb/bincnt_chain_tb.sv
`timescale 1ns/1ps
module bincnt_chain_tb;
    localparam int W   = 8;
    localparam int MAX = 255;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         load_n = 1'b1;
    logic [W-1:0] din = '0;
    logic         en_p = 1'b0;
    logic         en_t = 1'b0;
    logic [W-1:0] q_s, q_a;
    logic         tc_s, tc_a;

    int total = 0;
    int bad   = 0;
    int exp_s = 0;
    int exp_a = 0;
    bit done  = 1'b0;
    string cur_req = "R4";

    always #2.5 clk = ~clk;

    bincnt_chain #(.STAGE_W(4), .STAGES(2), .ASYNC_CLR(1'b0)) u_dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_s), .tc(tc_s));

    bincnt_chain #(.STAGE_W(4), .STAGES(2), .ASYNC_CLR(1'b1)) u_dut_async (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q_a), .tc(tc_a));

    // Reference model: precedence clear > load > count > hold.
    always @(posedge clk) begin
        if (!clr_n) begin
            exp_s = 0;
            exp_a = 0;
        end else if (!load_n) begin
            exp_s = int'(din);
            exp_a = int'(din);
        end else if (en_p && en_t) begin
            exp_s = (exp_s + 1) % (MAX + 1);
            exp_a = (exp_a + 1) % (MAX + 1);
        end
    end

    // The asynchronous variant clears the moment clr_n falls (R5).
    always @(negedge clr_n) exp_a = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk(cur_req, "sync q", int'(q_s), exp_s);
        chk(cur_req, "async q", int'(q_a), exp_a);
        chk("R6", "sync tc", int'(tc_s), int'(en_t && exp_s == MAX));
        chk("R6", "async tc", int'(tc_a), int'(en_t && exp_a == MAX));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic drive(input logic c, input logic l, input logic [W-1:0] d,
                         input logic p, input logic t);
        clr_n = c; load_n = l; din = d; en_p = p; en_t = t;
    endtask

    initial begin
        // Reset state: clear held low over edges (R4, R5).
        cur_req = "R4";
        @(posedge clk);
        @(negedge clk);
        tick();
        tick();

        // Wrap from all ones to zero with the terminal count (R1, R6).
        cur_req = "R3";
        drive(1, 0, 8'hFD, 1, 1);
        tick();
        cur_req = "R1";
        drive(1, 1, 8'h00, 1, 1);
        tick();
        tick();
        tick();
        tick();

        // Carry across the nibble boundary (R1).
        cur_req = "R3";
        drive(1, 0, 8'h0E, 1, 1);
        tick();
        cur_req = "R1";
        drive(1, 1, 8'h00, 1, 1);
        tick();
        tick();
        tick();

        // Terminal count ignores en_p and is gated by en_t (R6, R2).
        cur_req = "R3";
        drive(1, 0, 8'hFF, 0, 1);
        tick();
        cur_req = "R6";
        drive(1, 1, 8'h00, 0, 1);
        tick();
        cur_req = "R2";
        drive(1, 1, 8'h00, 1, 0);
        tick();
        tick();

        // Sweep every control combination from a known state (R1-style tags).
        for (int c = 0; c < 16; c++) begin
            cur_req = "R3";
            drive(1, 0, 8'h3C, 0, 0);
            tick();
            drive(c[3], c[2], 8'hA5, c[1], c[0]);
            if (!c[3])
                cur_req = "R4";
            else if (!c[2])
                cur_req = "R3";
            else if (c[1] && c[0])
                cur_req = "R1";
            else
                cur_req = "R2";
            tick();
        end

        // Clear pulse between edges: async clears now, sync waits (R5, R7).
        drive(1, 0, 8'h5A, 0, 0);
        cur_req = "R3";
        tick();
        drive(1, 1, 8'h00, 0, 0);
        #1;
        clr_n = 1'b0;
        #0.5;
        chk("R5", "async q mid-cycle", int'(q_a), 0);
        chk("R7", "sync q mid-cycle", int'(q_s), 'h5A);
        cur_req = "R4";
        tick();
        clr_n = 1'b1;
        cur_req = "R2";
        tick();

        // Mixed random traffic against the model.
        for (int i = 0; i < 400; i++) begin
            drive(($urandom % 20) != 0, ($urandom % 8) != 0, W'($urandom),
                  ($urandom % 4) != 0, ($urandom % 4) != 0);
            if (!clr_n)
                cur_req = "R4";
            else if (!load_n)
                cur_req = "R3";
            else if (en_p && en_t)
                cur_req = "R1";
            else
                cur_req = "R2";
            tick();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #900000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule